// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the single atomic reservation of one hardware thread. A load-reserve opens a reservation on the cache line holding its address and records whether it was a word or a doubleword access. A later store-conditional may write memory only if the reservation is still open, covers the same line, and was opened with the same access width. Any other store-conditional fails. It produces no memory write and reports a zero equal bit.

The pipeline presents one decoded operation per cycle. It gives the instruction word and its effective address under a strobe. Snoop logic or a context switch can cancel the reservation through a separate invalidate input. The store-conditional result appears one cycle after the strobe. It consists of a done pulse, the condition-register equal bit, and a write enable that carries the store width. Every store-conditional closes the reservation, whether it passes or fails.

Top module: `lrsc_monitor`

## Requirements
- R1: Reset closes the reservation: `rsv_width` reads 0, and `sc_done`, `cr0_eq`, `commit_en` and `commit_dword` are 0. A store-conditional after reset fails.
- R2: A word load-reserve sets the width code to 4. A doubleword load-reserve sets it to 8. Either one marks the reservation valid and records the line address, which is `ea` with its low log2(LINE_BYTES) bits cleared. A newer load-reserve replaces an older one.
- R3: A word store-conditional succeeds only if the reservation is valid with width code 4 on the same line. On success, `cr0_eq`=1 and `commit_en`=1 with `commit_dword`=0.
- R4: A doubleword store-conditional succeeds only if the reservation is valid with width code 8 on the same line. On success, `cr0_eq`=1 and `commit_en`=1 with `commit_dword`=1. A store-conditional that arrives in the same cycle as an invalidate is judged on the reservation held before that cycle.
- R5: A store-conditional whose width differs from the reservation width fails with `cr0_eq`=0 and `commit_en`=0.
- R6: A store-conditional to a line other than the reserved one fails.
- R7: Every store-conditional, whether it succeeds or fails, returns the width code to 0. A store-conditional with no reservation open fails.
- R8: `inval` closes the reservation and sets the width code to 0. If `inval` and a load-reserve occur in the same cycle, the load-reserve wins.
- R9: An operation is recognised only while `op_valid`=1, primary opcode `insn[31:26]`=31, and extended opcode `insn[10:1]` is one of the following, with the record bit `insn[0]` as given:
  - 20: word load-reserve, record bit 0
  - 84: doubleword load-reserve, record bit 0
  - 150: word store-conditional, record bit 1
  - 214: doubleword store-conditional, record bit 1
  Any other word, or a strobe held low, leaves the reservation untouched and produces no result.
- R10: `sc_done`, `cr0_eq`, `commit_en` and `commit_dword` are registered and valid in the cycle after the store-conditional strobe. They return to 0 in the following cycle unless another store-conditional arrives. `commit_en` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Strobe for `insn` and `ea` |
| insn | input | 32 | Instruction word of the decoded operation |
| ea | input | ADDR_W | Effective address of the operation |
| inval | input | 1 | Cancel the reservation (snoop hit or context switch) |
| sc_done | output | 1 | Store-conditional result valid |
| cr0_eq | output | 1 | Equal bit: 1 = store-conditional succeeded |
| commit_en | output | 1 | One-cycle enable for the memory write |
| commit_dword | output | 1 | Store width of the commit: 1 = doubleword, 0 = word |
| rsv_width | output | 4 | Reservation width code: 0 none, 4 word, 8 doubleword |

## Verification
The bench targets cross-width pairs. A design that matched on line alone would commit a doubleword after a word reservation, or the reverse. It also covers a store-conditional to a different line but the same low offset bits, which a mask that is too wide would let through. Other cases are an invalidate in the same cycle as a load-reserve, which a design giving invalidate priority would lose, and a repeated store-conditional, which a design that forgot to clear the reservation on failure or success would accept. Near-miss instruction words are included: a store-conditional without its record bit, a wrong primary opcode, and a valid instruction with the strobe low. Each must leave an open reservation intact and produce no result.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int ADDR_W     = 64,
  parameter int LINE_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [31:0]       insn,
  input  logic [ADDR_W-1:0] ea,
  input  logic              inval,
  output logic              sc_done,
  output logic              cr0_eq,
  output logic              commit_en,
  output logic              commit_dword,
  output logic [3:0]        rsv_width
);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFS_W;
  localparam logic [5:0] PRIMARY = 6'd31;
  localparam logic [9:0] XO_LRW = 10'd20;
  localparam logic [9:0] XO_LRD = 10'd84;
  localparam logic [9:0] XO_SCW = 10'd150;
  localparam logic [9:0] XO_SCD = 10'd214;
  localparam logic [3:0] W_NONE = 4'd0;
  localparam logic [3:0] W_WORD = 4'd4;
  localparam logic [3:0] W_DBL  = 4'd8;

  logic              rsv_valid;
  logic [LINE_W-1:0] rsv_line;
  logic              grp, is_lrw, is_lrd, is_scw, is_scd, is_lr, is_sc;
  logic [LINE_W-1:0] op_line;
  logic              line_hit, sc_ok;
  logic              unused_bits;

  assign grp     = op_valid && insn[31:26] == PRIMARY;
  assign is_lrw  = grp && insn[10:1] == XO_LRW && !insn[0];
  assign is_lrd  = grp && insn[10:1] == XO_LRD && !insn[0];
  assign is_scw  = grp && insn[10:1] == XO_SCW &&  insn[0];
  assign is_scd  = grp && insn[10:1] == XO_SCD &&  insn[0];
  assign is_lr   = is_lrw || is_lrd;
  assign is_sc   = is_scw || is_scd;

  assign op_line  = ea[ADDR_W-1:OFS_W];
  assign line_hit = rsv_valid && rsv_line == op_line;
  assign sc_ok    = line_hit &&
                    ((is_scw && rsv_width == W_WORD) || (is_scd && rsv_width == W_DBL));

  assign unused_bits = ^{insn[25:11], ea[OFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsv_valid <= 1'b0;
      rsv_width <= W_NONE;
      rsv_line  <= '0;
    end else if (is_lr) begin
      rsv_valid <= 1'b1;
      rsv_width <= is_lrd ? W_DBL : W_WORD;
      rsv_line  <= op_line;
    end else if (is_sc || inval) begin
      rsv_valid <= 1'b0;
      rsv_width <= W_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_done      <= 1'b0;
      cr0_eq       <= 1'b0;
      commit_en    <= 1'b0;
      commit_dword <= 1'b0;
    end else begin
      sc_done      <= is_sc;
      cr0_eq       <= sc_ok;
      commit_en    <= sc_ok;
      commit_dword <= sc_ok && is_scd;
    end
  end
endmodule

module lrsc_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       inval,
  input logic       sc_done,
  input logic       cr0_eq,
  input logic       commit_en,
  input logic       commit_dword,
  input logic [3:0] rsv_width
);
  // R10
  commit_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> (sc_done && cr0_eq));
  // R10
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> !commit_en);
  // R7
  sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> rsv_width == 4'd0);
  // R2
  width_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_width == 4'd0 || rsv_width == 4'd4 || rsv_width == 4'd8);
  // R5
  width_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !commit_en && !op_valid) |=>
      !commit_en || (sc_done && $past(rsv_width) == (commit_dword ? 4'd8 : 4'd4)));
  // R8
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inval && !op_valid) |=> rsv_width == 4'd0);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !inval) |=> ($stable(rsv_width) && !sc_done));
endmodule

bind lrsc_monitor lrsc_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .inval(inval),
  .sc_done(sc_done), .cr0_eq(cr0_eq), .commit_en(commit_en),
  .commit_dword(commit_dword), .rsv_width(rsv_width)
);

// File: tb/sim_lrsc_monitor.sv
module sim_lrsc_monitor;
  localparam int ADDR_W = 64;
  localparam int NV = 25;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              op_valid = 1'b0;
  logic [31:0]       insn = '0;
  logic [ADDR_W-1:0] ea = '0;
  logic              inval = 1'b0;
  logic              sc_done, cr0_eq, commit_en, commit_dword;
  logic [3:0]        rsv_width;

  int applied = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  lrsc_monitor #(.ADDR_W(ADDR_W), .LINE_BYTES(128)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .insn(insn), .ea(ea),
    .inval(inval), .sc_done(sc_done), .cr0_eq(cr0_eq), .commit_en(commit_en),
    .commit_dword(commit_dword), .rsv_width(rsv_width)
  );

  // kind: 0 idle, 1 lr word, 2 lr dword, 3 sc word, 4 sc dword,
  // 5 xo150 without record bit, 6 wrong primary opcode, 7 sc word with strobe low
  // fields: kind[29:27] ea[26:11] inval[10] done[9] eq[8] width[7:4] req[3:0]
  localparam logic [29:0] VEC [NV] = '{
    {3'd1, 16'h1000, 1'b0, 1'b0, 1'b0, 4'd4, 4'd2},  // R2
    {3'd3, 16'h1004, 1'b0, 1'b1, 1'b1, 4'd0, 4'd3},  // R3
    {3'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd0, 4'd10}, // R10
    {3'd1, 16'h1000, 1'b0, 1'b0, 1'b0, 4'd4, 4'd2},
    {3'd4, 16'h1000, 1'b0, 1'b1, 1'b0, 4'd0, 4'd5},  // R5
    {3'd2, 16'h2000, 1'b0, 1'b0, 1'b0, 4'd8, 4'd2},
    {3'd3, 16'h2000, 1'b0, 1'b1, 1'b0, 4'd0, 4'd5},
    {3'd2, 16'h2000, 1'b0, 1'b0, 1'b0, 4'd8, 4'd2},
    {3'd4, 16'h2078, 1'b0, 1'b1, 1'b1, 4'd0, 4'd4},  // R4
    {3'd4, 16'h2000, 1'b0, 1'b1, 1'b0, 4'd0, 4'd7},  // R7
    {3'd1, 16'h3000, 1'b0, 1'b0, 1'b0, 4'd4, 4'd2},
    {3'd3, 16'h3080, 1'b0, 1'b1, 1'b0, 4'd0, 4'd6},  // R6
    {3'd1, 16'h3000, 1'b1, 1'b0, 1'b0, 4'd4, 4'd8},  // R8
    {3'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0, 4'd8},
    {3'd3, 16'h3000, 1'b0, 1'b1, 1'b0, 4'd0, 4'd8},
    {3'd2, 16'h4000, 1'b0, 1'b0, 1'b0, 4'd8, 4'd2},
    {3'd1, 16'h4100, 1'b0, 1'b0, 1'b0, 4'd4, 4'd2},
    {3'd4, 16'h4100, 1'b0, 1'b1, 1'b0, 4'd0, 4'd5},
    {3'd1, 16'h5000, 1'b0, 1'b0, 1'b0, 4'd4, 4'd2},
    {3'd5, 16'h5000, 1'b0, 1'b0, 1'b0, 4'd4, 4'd9},  // R9
    {3'd7, 16'h5000, 1'b0, 1'b0, 1'b0, 4'd4, 4'd9},
    {3'd6, 16'h5000, 1'b0, 1'b0, 1'b0, 4'd4, 4'd9},
    {3'd3, 16'h5010, 1'b0, 1'b1, 1'b1, 4'd0, 4'd3},
    {3'd2, 16'h6000, 1'b0, 1'b0, 1'b0, 4'd8, 4'd2},
    {3'd4, 16'h6000, 1'b1, 1'b1, 1'b1, 4'd0, 4'd4}
  };

  function automatic logic [31:0] enc(input logic [5:0] po, input logic [9:0] xo, input logic rc);
    return {po, 5'd6, 5'd4, 5'd5, xo, rc};
  endfunction

  function automatic logic [31:0] insn_of(input logic [2:0] kind);
    case (kind)
      3'd1: return enc(6'd31, 10'd20, 1'b0);
      3'd2: return enc(6'd31, 10'd84, 1'b0);
      3'd3, 3'd7: return enc(6'd31, 10'd150, 1'b1);
      3'd4: return enc(6'd31, 10'd214, 1'b1);
      3'd5: return enc(6'd31, 10'd150, 1'b0);
      3'd6: return enc(6'd30, 10'd150, 1'b1);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input int req, input logic [3:0] got, input logic [3:0] exp);
    applied++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL R%0d: {done,eq,commit,dword}/width got %b exp %b", req, got, exp);
    end
  endtask

  task automatic check_w(input int req, input logic [3:0] got, input logic [3:0] exp);
    applied++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL R%0d: rsv_width got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] kind, input logic [15:0] a, input logic iv);
    op_valid = (kind != 3'd0) && (kind != 3'd7);
    insn     = insn_of(kind);
    ea       = {{(ADDR_W-16){1'b0}}, a};
    inval    = iv;
    @(negedge clk);
    op_valid = 1'b0;
    inval    = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(1, {sc_done, cr0_eq, commit_en, commit_dword}, 4'b0000);
    check_w(1, rsv_width, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      logic [3:0] exp_o;
      v = VEC[i];
      drive(v[29:27], v[26:11], v[10]);
      exp_o = {v[9], v[8], v[9] & v[8], v[9] & v[8] & (v[29:27] == 3'd4)};
      check(int'(v[3:0]), {sc_done, cr0_eq, commit_en, commit_dword}, exp_o);
      check_w(int'(v[3:0]), rsv_width, v[7:4]);
    end

    // R1: reset in the middle of an open reservation
    drive(3'd1, 16'h7000, 1'b0);
    check_w(2, rsv_width, 4'd4);
    rst_n = 1'b0;
    @(negedge clk);
    check_w(1, rsv_width, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(3'd3, 16'h7000, 1'b0);
    check(1, {sc_done, cr0_eq, commit_en, commit_dword}, 4'b1000);

    // R10: back-to-back store-conditionals after one reservation
    drive(3'd2, 16'h8000, 1'b0);
    drive(3'd4, 16'h8000, 1'b0);
    check(10, {sc_done, cr0_eq, commit_en, commit_dword}, 4'b1111);
    drive(3'd4, 16'h8000, 1'b0);
    check(10, {sc_done, cr0_eq, commit_en, commit_dword}, 4'b1000);
    drive(3'd0, 16'h0000, 1'b0);
    check(10, {sc_done, cr0_eq, commit_en, commit_dword}, 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule